// File: doc/BRIEF.md
# Nibble DRAM Fetch Sequencer

This block reads one display byte at a time from a dynamic RAM array that stores data as 4-bit words. The work is done in fixed slots of eight phases, one phase per clock. In a fetch slot the block places the row part of the byte address on a multiplexed address bus and drops the row strobe. It then presents two column addresses that differ only in their lowest bit, drops the column strobe for each, and captures one nibble per column. The first nibble becomes the upper half of the byte and the second nibble the lower half. As a result, byte N lives in nibble words 2N and 2N+1.

Not every slot fetches. A slot divider counts slots and permits a fetch only when its count is zero. The divider period is 80 divided by the number of bytes the current line needs, so a line of 80 bytes can fetch in every slot and a line of 40 bytes in every second slot. The request and the byte address are sampled once per slot, at the end of phase 0.

Top module: `nib_fetch_seq`

## Requirements
- R1: In a fetch slot, ras_n is low in phases 1 to 6 and cas_n is low in phases 2, 3, 5 and 6. Both strobes are high in phases 0 and 7, and cas_n is never low while ras_n is high.
- R2: In phase 0 of every slot, mem_addr carries byte_addr[15:7] taken live from the input.
- R3: In phases 1 to 3 of a fetch slot, mem_addr is {addr[6:0],0}. In phases 4 to 6 it is {addr[6:0],1}, where addr is the byte address sampled at the end of phase 0. mem_addr does not change while cas_n stays low.
- R4: byte_data is {nibble captured at the end of phase 3, nibble captured at the end of phase 6}. Byte N is therefore read from nibble word {row,column} = 2N for the high half and 2N+1 for the low half.
- R5: byte_valid is high for exactly one cycle per fetch. That cycle is phase 7 of the fetch slot, during which both strobes are high.
- R6: fetch_req and byte_addr are sampled only at the end of phase 0. Changes to them later in the slot affect neither the strobes, the column addresses nor the delivered byte.
- R7: A slot may fetch only when the slot count is 0. The count advances at the end of every slot and wraps to 0 when count+1 reaches D. D is 80/bytes_per_line, with 0 bytes giving D=80 and more than 80 bytes giving D=1.
- R8: During and right after reset, the phase is 0, the slot count is 0, both strobes are high and byte_valid is low.
- R9: A slot without a request, or one the divider does not permit, leaves both strobes high and produces no byte_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one phase per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Request to fetch a byte in this slot, sampled at the end of phase 0 |
| byte_addr | input | 16 | Byte address to fetch |
| bytes_per_line | input | 7 | Bytes needed per line; sets the divider period |
| mem_addr | output | 9 | Multiplexed row/column address to the DRAM |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe |
| nib_in | input | 4 | Nibble returned by the DRAM |
| byte_valid | output | 1 | One-cycle pulse when byte_data holds a new byte |
| byte_data | output | 8 | Assembled byte, high nibble first |

## Verification
The bench uses addresses at the edges of the row and column fields (0x0000, 0xFFFF, 0x007F, 0x0080). A design that swapped the nibble halves, or dropped the column LSB, would return the wrong byte from the computed memory pattern. Midway through each slot the bench inverts byte_addr and fetch_req. A design that sampled them late would strobe the wrong column or start and stop fetching on its own. The bench also switches between divider periods of 1, 2, 4 and 80, including a reload where the old count is larger than the new period. A divider that loaded the wrong period or failed to wrap would fetch in slots the scoreboard does not expect, or skip slots it does expect.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

   typedef enum logic [2:0] {
      PH_ROW  = 3'd0,
      PH_RAS  = 3'd1,
      PH_COLA = 3'd2,
      PH_HI   = 3'd3,
      PH_COLB = 3'd4,
      PH_CASB = 3'd5,
      PH_LO   = 3'd6,
      PH_END  = 3'd7
   } phase_e;

   function automatic logic row_low(input phase_e p);
      return (p != PH_ROW) && (p != PH_END);
   endfunction

   function automatic logic col_low(input phase_e p);
      return (p == PH_COLA) || (p == PH_HI) || (p == PH_CASB) || (p == PH_LO);
   endfunction

endpackage

// File: rtl/nfs_phase_ctr.sv
module nfs_phase_ctr
   import nfs_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   output phase_e phase
);
   always_ff @(posedge clk) begin
      if (!rst_n) phase <= PH_ROW;
      else        phase <= phase_e'(3'(phase + 3'd1));
   end
endmodule

// File: rtl/nfs_slot_div.sv
module nfs_slot_div #(
   parameter int LINE_SLOTS = 80,
   parameter int BPL_W      = 7,
   parameter int DIV_W      = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_end,
   input  logic [BPL_W-1:0] bytes_per_line,
   output logic             slot_open
);
   localparam logic [DIV_W-1:0] SLOTS_V = DIV_W'(LINE_SLOTS);

   if (BPL_W > DIV_W) begin : g_bad_width
      $error("nfs_slot_div: BPL_W must not exceed DIV_W");
   end

   logic [DIV_W-1:0] cnt_q, period, quot, cnt_inc;

   always_comb begin
      quot = SLOTS_V / DIV_W'(bytes_per_line == '0 ? BPL_W'(1) : bytes_per_line);
      if (bytes_per_line == '0) period = SLOTS_V;
      else if (quot == '0)      period = DIV_W'(1);
      else                      period = quot;
      cnt_inc = cnt_q + DIV_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (slot_end) cnt_q <= (cnt_inc >= period) ? '0 : cnt_inc;
   end

   assign slot_open = (cnt_q == '0);
endmodule

// File: rtl/nfs_addr_strobe.sv
module nfs_addr_strobe
   import nfs_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int COL_BITS = 7,
   parameter int MA_W     = 9
) (
   input  phase_e            phase,
   input  logic              active,
   input  logic [ADDR_W-1:0] live_addr,
   input  logic [ADDR_W-1:0] held_addr,
   output logic [MA_W-1:0]   mem_addr,
   output logic              ras_n,
   output logic              cas_n
);
   localparam int ROW_W = ADDR_W - COL_BITS;
   localparam int CAW   = COL_BITS + 1;

   logic [MA_W-1:0] row_ma, cola_ma, colb_ma;
   logic [CAW-1:0]  cola, colb;

   assign cola = {held_addr[COL_BITS-1:0], 1'b0};
   assign colb = {held_addr[COL_BITS-1:0], 1'b1};

   if (MA_W > ROW_W) begin : g_row_pad
      assign row_ma = {{(MA_W-ROW_W){1'b0}}, live_addr[ADDR_W-1:COL_BITS]};
   end else begin : g_row_full
      assign row_ma = live_addr[ADDR_W-1:COL_BITS];
   end

   if (MA_W > CAW) begin : g_col_pad
      assign cola_ma = {{(MA_W-CAW){1'b0}}, cola};
      assign colb_ma = {{(MA_W-CAW){1'b0}}, colb};
   end else begin : g_col_full
      assign cola_ma = cola;
      assign colb_ma = colb;
   end

   always_comb begin
      unique case (phase)
         PH_ROW:                  mem_addr = row_ma;
         PH_RAS, PH_COLA, PH_HI:  mem_addr = cola_ma;
         default:                 mem_addr = colb_ma;
      endcase
      ras_n = !(active && row_low(phase));
      cas_n = !(active && col_low(phase));
   end
endmodule

// File: rtl/nfs_nibble_join.sv
module nfs_nibble_join
   import nfs_pkg::*;
#(
   parameter int NIB_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  phase_e             phase,
   input  logic               active,
   input  logic [NIB_W-1:0]   nib_in,
   output logic [2*NIB_W-1:0] byte_data,
   output logic               byte_valid
);
   logic [NIB_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q       <= '0;
         byte_data  <= '0;
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         if (active && phase == PH_HI) hi_q <= nib_in;
         if (active && phase == PH_LO) begin
            byte_data  <= {hi_q, nib_in};
            byte_valid <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/nib_fetch_seq.sv
module nib_fetch_seq
   import nfs_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int COL_BITS   = 7,
   parameter int NIB_W      = 4,
   parameter int LINE_SLOTS = 80,
   parameter int BPL_W      = 7,
   localparam int ROW_W     = ADDR_W - COL_BITS,
   localparam int CAW       = COL_BITS + 1,
   localparam int MA_W      = (ROW_W > CAW) ? ROW_W : CAW,
   localparam int DIV_W     = $clog2(LINE_SLOTS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fetch_req,
   input  logic [ADDR_W-1:0]  byte_addr,
   input  logic [BPL_W-1:0]   bytes_per_line,
   output logic [MA_W-1:0]    mem_addr,
   output logic               ras_n,
   output logic               cas_n,
   input  logic [NIB_W-1:0]   nib_in,
   output logic               byte_valid,
   output logic [2*NIB_W-1:0] byte_data
);
   if (COL_BITS < 1 || COL_BITS >= ADDR_W) begin : g_bad_split
      $error("nib_fetch_seq: COL_BITS must lie inside the address");
   end
   if (LINE_SLOTS < 1) begin : g_bad_slots
      $error("nib_fetch_seq: LINE_SLOTS must be positive");
   end

   phase_e            phase;
   logic              slot_open;
   logic              active_q;
   logic [ADDR_W-1:0] held_q;

   nfs_phase_ctr i_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase)
   );

   nfs_slot_div #(
      .LINE_SLOTS (LINE_SLOTS),
      .BPL_W      (BPL_W),
      .DIV_W      (DIV_W)
   ) i_div (
      .clk            (clk),
      .rst_n          (rst_n),
      .slot_end       (phase == PH_END),
      .bytes_per_line (bytes_per_line),
      .slot_open      (slot_open)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         held_q   <= '0;
      end else if (phase == PH_ROW) begin
         active_q <= fetch_req && slot_open;
         held_q   <= byte_addr;
      end else if (phase == PH_END) begin
         active_q <= 1'b0;
      end
   end

   nfs_addr_strobe #(
      .ADDR_W   (ADDR_W),
      .COL_BITS (COL_BITS),
      .MA_W     (MA_W)
   ) i_mux (
      .phase     (phase),
      .active    (active_q),
      .live_addr (byte_addr),
      .held_addr (held_q),
      .mem_addr  (mem_addr),
      .ras_n     (ras_n),
      .cas_n     (cas_n)
   );

   nfs_nibble_join #(
      .NIB_W (NIB_W)
   ) i_join (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .active     (active_q),
      .nib_in     (nib_in),
      .byte_data  (byte_data),
      .byte_valid (byte_valid)
   );
endmodule

// File: rtl/nfs_chk.sv
module nfs_chk #(
   parameter int MA_W = 9
) (
   input logic            clk,
   input logic            rst_n,
   input logic [MA_W-1:0] mem_addr,
   input logic            ras_n,
   input logic            cas_n,
   input logic            byte_valid
);
   // R1
   cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   // R1
   ras_then_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |=> $fell(cas_n));

   // R3
   col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && !$fell(cas_n)) |-> $stable(mem_addr));

   // R5
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);

   // R5
   valid_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> (ras_n && cas_n));

   // R5
   row_release_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> byte_valid);
endmodule

bind nib_fetch_seq nfs_chk #(.MA_W(MA_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_addr   (mem_addr),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .byte_valid (byte_valid)
);

// File: tb/test_nib_fetch_seq.sv
`timescale 1ns/1ps
module test_nib_fetch_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req = 1'b0;
   logic [15:0] byte_addr = '0;
   logic [6:0]  bytes_per_line = 7'd80;
   logic [8:0]  mem_addr;
   logic        ras_n, cas_n;
   logic [3:0]  nib_in = '0;
   logic        byte_valid;
   logic [7:0]  byte_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   nib_fetch_seq i_nib_fetch_seq (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .byte_addr(byte_addr),
      .bytes_per_line(bytes_per_line), .mem_addr(mem_addr), .ras_n(ras_n),
      .cas_n(cas_n), .nib_in(nib_in), .byte_valid(byte_valid), .byte_data(byte_data)
   );

   function automatic logic [3:0] fnib(input logic [16:0] i);
      logic [16:0] t;
      t = i ^ (i >> 5) ^ (i >> 11);
      return t[3:0] ^ t[7:4] ^ {i[0], i[16], i[9], i[1]};
   endfunction

   function automatic int period(input logic [6:0] bpl);
      if (bpl == 0) return 80;
      if (80 / bpl == 0) return 1;
      return 80 / bpl;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // bench's own slot-phase count
   int bph = 0;
   always @(posedge clk) bph <= (!rst_n) ? 0 : (bph + 1) % 8;

   // DRAM model: strobe falling edge latches the address presented the phase before
   logic [8:0] pma = '0, mrow = '0;
   logic [7:0] mcol = '0;
   logic       pras = 1'b1, pcas = 1'b1;
   always @(negedge clk) begin
      if (!ras_n && pras) mrow = pma;
      if (!cas_n && pcas) begin
         mcol   = pma[7:0];
         nib_in = fnib({mrow, mcol});
      end
      pras = ras_n;
      pcas = cas_n;
      pma  = mem_addr;
   end

   // scoreboard
   logic [7:0] exp_q[$];
   always @(negedge clk) begin
      if (rst_n && byte_valid) begin
         check(bph == 7, "R5 valid phase", bph, 7);
         if (exp_q.size() == 0) check(0, "R9 unexpected byte", byte_data, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(byte_data == e, "R4 byte", byte_data, e);
         end
      end
   end

   int bdiv = 0;

   // starts and ends at a phase-7 negedge
   task automatic run_slot(input logic req, input logic [15:0] a, input logic [6:0] bpl);
      bit fetch;
      fetch_req = req; byte_addr = a; bytes_per_line = bpl;
      bdiv = (bdiv + 1 >= period(bpl)) ? 0 : bdiv + 1;   // R7
      fetch = req && (bdiv == 0);
      if (fetch) exp_q.push_back({fnib({a, 1'b0}), fnib({a, 1'b1})});
      @(negedge clk);   // phase 0
      check(mem_addr == {a[15:7]}, "R2 row addr", mem_addr, a[15:7]);
      check(ras_n && cas_n, "R1 phase0 strobes", {ras_n, cas_n}, 3);
      @(negedge clk);   // phase 1
      if (fetch) begin
         check(!ras_n && cas_n, "R1 phase1 strobes", {ras_n, cas_n}, 1);
         check(mem_addr == {1'b0, a[6:0], 1'b0}, "R3 col A", mem_addr, {1'b0, a[6:0], 1'b0});
      end else
         check(ras_n && cas_n, "R9 R7 idle slot", {ras_n, cas_n}, 3);
      @(negedge clk);   // phase 2: disturb inputs, R6
      byte_addr = ~a; fetch_req = ~req;
      check(cas_n == !fetch, "R1 R6 phase2 cas", cas_n, !fetch);
      @(negedge clk);   // phase 3
      @(negedge clk);   // phase 4
      if (fetch) begin
         check(!ras_n && cas_n, "R1 phase4 strobes", {ras_n, cas_n}, 1);
         check(mem_addr == {1'b0, a[6:0], 1'b1}, "R3 R6 col B", mem_addr, {1'b0, a[6:0], 1'b1});
      end else
         check(ras_n, "R9 idle ras", ras_n, 1);
      @(negedge clk);   // phase 5
      @(negedge clk);   // phase 6
      check(cas_n == !fetch, "R1 phase6 cas", cas_n, !fetch);
      @(negedge clk);   // phase 7
      check(ras_n && cas_n, "R1 phase7 strobes", {ras_n, cas_n}, 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(ras_n && cas_n && !byte_valid, "R8 reset outputs", {ras_n, cas_n, byte_valid}, 6);
      rst_n = 1'b1;
      check(mem_addr == 9'd0, "R8 phase0 after reset", mem_addr, 0);
      while (bph != 7) @(negedge clk);
      run_slot(1'b0, 16'h0000, 7'd80);
      run_slot(1'b1, 16'h0000, 7'd80);
      run_slot(1'b1, 16'hFFFF, 7'd80);
      run_slot(1'b1, 16'h1234, 7'd80);
      run_slot(1'b1, 16'h007F, 7'd80);
      run_slot(1'b1, 16'h0080, 7'd80);
      run_slot(1'b0, 16'h5555, 7'd80);
      for (int k = 0; k < 4; k++) run_slot(1'b1, 16'h3000 + 16'(k), 7'd40);
      for (int k = 0; k < 8; k++) run_slot(1'b1, 16'h4A10 + 16'(k * 3), 7'd20);
      for (int k = 0; k < 2; k++) run_slot(1'b1, 16'hC3C3 + 16'(k), 7'd100);
      for (int k = 0; k < 3; k++) run_slot(1'b1, 16'h2468 + 16'(k), 7'd0);
      run_slot(1'b1, 16'hBEEF, 7'd80);
      run_slot(1'b0, 16'h0000, 7'd80);
      check(exp_q.size() == 0, "R4 R7 all bytes delivered", exp_q.size(), 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule